// File: doc/BRIEF.md
# Load-Store Byte Alignment Unit

This block sits between a 32-bit register datapath and a data memory that is read and written one 32-bit word at a time but addressed in bytes. On a load, it takes the word returned by memory, the access width, a signedness flag and the low address bits. It picks the addressed byte, halfword or word and widens it to the full register width, either with the sign bit repeated or with zeros.

On a store, it copies the low byte or halfword of the source register into the memory lane that the address names. It also drives one write enable per byte lane. Bytes are big-endian: the lowest address in a word is the most significant byte.

Alignment is strict. An access whose address is not a multiple of its width, or whose width code is not legal, raises a trap flag. When the trap is raised, every write enable is held low and the load result is zero. The unit has no registers. The load result and the store lanes are valid in the same cycle as their inputs, so aligned accesses cost no extra cycles.

Top module: `lsa_unit`

## Requirements
- R1: The width code `req_size` is 2'b00 for byte, 2'b01 for halfword, 2'b10 for word, and 2'b11 is illegal. `align_trap` is high exactly when the width is illegal or `addr_lo` is not a multiple of the width in bytes. So a byte never traps, a halfword traps on odd `addr_lo`, and a word traps on any nonzero `addr_lo`.
- R2: Byte lanes are big-endian. A byte load at offset k takes `mem_rdata` bits [31-8k:24-8k]. A halfword load at offset 0 takes bits 31:16, and at offset 2 it takes bits 15:0.
- R3: When `load_unsigned` is 0, a byte or halfword load copies bit 7 or bit 15 of the selected value into every higher bit of `load_result`.
- R4: When `load_unsigned` is 1, a byte or halfword load fills the bits above the selected value with zeros.
- R5: An aligned word load returns `mem_rdata` unchanged, whatever the value of `load_unsigned`.
- R6: On a byte store, the byte `store_src[7:0]` is copied into all four lanes of `mem_wdata`. Bit i of `mem_be` enables `mem_wdata[8i+7:8i]`, and for offset k only bit 3-k is set.
- R7: On a halfword store, `store_src[15:0]` is copied into both halves of `mem_wdata`. `mem_be` is 4'b1100 at offset 0 and 4'b0011 at offset 2.
- R8: On an aligned word store, `mem_wdata` equals `store_src` and `mem_be` is 4'b1111.
- R9: While `align_trap` is high, `mem_be` is 4'b0000 and `load_result` is zero.
- R10: While `store_req` is 0, `mem_be` is 4'b0000. The load path is computed whatever the value of `store_req`.
- R11: The unit is purely combinational. Its outputs follow its inputs within the same cycle, with no clock edge between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_size | input | 2 | Access width code |
| load_unsigned | input | 1 | 1 selects zero extension for byte and halfword loads |
| addr_lo | input | 2 | Byte offset of the access within the word |
| store_req | input | 1 | The access is a store |
| store_src | input | 32 | Register value to be stored |
| mem_rdata | input | 32 | Word returned by the memory |
| load_result | output | 32 | Extracted and extended load value |
| mem_wdata | output | 32 | Store data placed in its lanes |
| mem_be | output | 4 | Per-byte write enables; bit i enables bits 8i+7:8i |
| align_trap | output | 1 | Misaligned access or illegal width |

## Verification
The checker evaluates its properties only once every control input (width code, offset, store request, signedness) holds a known value. Before that point, the outputs of a purely combinational block carry no meaning. The bench keeps within that condition by driving every input to a defined value from time zero. It changes the inputs only on the falling clock edge and gives the logic time to settle before it samples. Over several data patterns, the sweep covers every combination of width code, offset, signedness and store request, including the illegal width code.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_BAD  = 2'b11
    } acc_size_e;

    // Width of an access in bytes; zero marks the illegal code.
    function automatic int unsigned size_bytes(acc_size_e s);
        case (s)
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            SZ_WORD: return 4;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/lsa_align_check.sv
module lsa_align_check
    import lsa_pkg::*;
#(
    parameter int OFF_W = 2
) (
    input  acc_size_e        size,
    input  logic [OFF_W-1:0] off,
    output logic             trap
);
    always_comb begin
        case (size)
            SZ_BYTE: trap = 1'b0;
            SZ_HALF: trap = off[0];
            SZ_WORD: trap = |off;
            default: trap = 1'b1;
        endcase
    end
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int OFF_W  = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] rdata,
    input  acc_size_e         size,
    input  logic              zext,
    input  logic [OFF_W-1:0]  off,
    input  logic              trap,
    output logic [DATA_W-1:0] result
);
    logic [DATA_W-1:0] shifted;

    always_comb begin
        int sh;
        sh = (LANES - int'(off) - int'(size_bytes(size))) * 8;
        if (sh < 0) sh = 0;
        shifted = rdata >> sh;
    end

    always_comb begin
        result = '0;
        if (!trap) begin
            case (size)
                SZ_BYTE: result = zext ? {{(DATA_W-8){1'b0}}, shifted[7:0]}
                                       : {{(DATA_W-8){shifted[7]}}, shifted[7:0]};
                SZ_HALF: result = zext ? {{(DATA_W-16){1'b0}}, shifted[15:0]}
                                       : {{(DATA_W-16){shifted[15]}}, shifted[15:0]};
                SZ_WORD: result = shifted;
                default: result = '0;
            endcase
        end
    end
endmodule

// File: rtl/lsa_store_place.sv
module lsa_store_place
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int OFF_W  = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] src,
    input  acc_size_e         size,
    input  logic [OFF_W-1:0]  off,
    input  logic              st_req,
    input  logic              trap,
    output logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  be
);
    // Lane index that holds the byte at the addressed offset.
    logic [OFF_W-1:0] tgt_lane;
    assign tgt_lane = OFF_W'(LANES - 1) - off;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [OFF_W-1:0] LI = OFF_W'(i);
        logic hit;

        always_comb begin
            case (size)
                SZ_BYTE: wdata[8*i +: 8] = src[7:0];
                SZ_HALF: wdata[8*i +: 8] = src[8*(i%2) +: 8];
                default: wdata[8*i +: 8] = src[8*i +: 8];
            endcase
        end

        always_comb begin
            case (size)
                SZ_BYTE: hit = (LI == tgt_lane);
                SZ_HALF: hit = (LI[OFF_W-1:1] == tgt_lane[OFF_W-1:1]);
                SZ_WORD: hit = 1'b1;
                default: hit = 1'b0;
            endcase
        end

        assign be[i] = hit & st_req & ~trap;
    end
endmodule

// File: rtl/lsa_unit.sv
module lsa_unit
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic [1:0]        req_size,
    input  logic              load_unsigned,
    input  logic [OFF_W-1:0]  addr_lo,
    input  logic              store_req,
    input  logic [DATA_W-1:0] store_src,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] load_result,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [LANES-1:0]  mem_be,
    output logic              align_trap
);
    acc_size_e sz;
    logic      trap;

    assign sz = acc_size_e'(req_size);

    lsa_align_check #(.OFF_W(OFF_W)) u_chk (
        .size (sz),
        .off  (addr_lo),
        .trap (trap)
    );

    lsa_load_extract #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) u_ld (
        .rdata  (mem_rdata),
        .size   (sz),
        .zext   (load_unsigned),
        .off    (addr_lo),
        .trap   (trap),
        .result (load_result)
    );

    lsa_store_place #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) u_st (
        .src    (store_src),
        .size   (sz),
        .off    (addr_lo),
        .st_req (store_req),
        .trap   (trap),
        .wdata  (mem_wdata),
        .be     (mem_be)
    );

    assign align_trap = trap;
endmodule

// File: rtl/lsa_checker.sv
module lsa_checker #(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int OFF_W  = $clog2(LANES)
) (
    input logic [1:0]        req_size,
    input logic              load_unsigned,
    input logic [OFF_W-1:0]  addr_lo,
    input logic              store_req,
    input logic [DATA_W-1:0] load_result,
    input logic [LANES-1:0]  mem_be,
    input logic              align_trap
);
    always_comb begin
        if (!$isunknown({req_size, load_unsigned, addr_lo, store_req})) begin
            if (req_size == 2'b00)
                a_r1_byte_never_traps: assert (!align_trap);
            if (req_size == 2'b01 && addr_lo[0])
                a_r1_odd_half_traps: assert (align_trap);
            if (align_trap)
                a_r9_trap_blocks_write: assert (mem_be == '0);
            if (align_trap)
                a_r9_trap_zero_load: assert (load_result == '0);
            if (!store_req)
                a_r10_no_store_no_enable: assert (mem_be == '0);
            if (store_req && !align_trap)
                a_r6_enable_count: assert ($countones(mem_be) == (1 << req_size));
            if (!align_trap && req_size == 2'b00 && load_unsigned)
                a_r4_byte_zero_fill: assert (load_result[DATA_W-1:8] == '0);
            if (!align_trap && req_size == 2'b01 && !load_unsigned)
                a_r3_half_sign_fill: assert (load_result[DATA_W-1:16] == {(DATA_W-16){load_result[15]}});
        end
    end
endmodule

bind lsa_unit lsa_checker #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) u_lsa_checker (
    .req_size      (req_size),
    .load_unsigned (load_unsigned),
    .addr_lo       (addr_lo),
    .store_req     (store_req),
    .load_result   (load_result),
    .mem_be        (mem_be),
    .align_trap    (align_trap)
);

// File: tb/lsa_unit_test.sv
module lsa_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  req_size = 2'b00;
    logic        load_unsigned = 1'b0;
    logic [1:0]  addr_lo = 2'b00;
    logic        store_req = 1'b0;
    logic [31:0] store_src = 32'h0;
    logic [31:0] mem_rdata = 32'h0;
    logic [31:0] load_result;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_be;
    logic        align_trap;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lsa_unit uut (
        .req_size      (req_size),
        .load_unsigned (load_unsigned),
        .addr_lo       (addr_lo),
        .store_req     (store_req),
        .store_src     (store_src),
        .mem_rdata     (mem_rdata),
        .load_result   (load_result),
        .mem_wdata     (mem_wdata),
        .mem_be        (mem_be),
        .align_trap    (align_trap)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s size=%0d uns=%0d off=%0d st=%0d actual=%h expected=%h",
                     req, req_size, load_unsigned, addr_lo, store_req, act, exp);
        end
    endtask

    initial begin
        logic [31:0] rpat [6];
        logic [31:0] spat [6];
        rpat[0] = 32'h12345678; spat[0] = 32'hA5C3_1E0F;
        rpat[1] = 32'h80FF7F01; spat[1] = 32'h0000_80FF;
        rpat[2] = 32'hFEDCBA98; spat[2] = 32'h1357_9BDF;
        rpat[3] = 32'h00000000; spat[3] = 32'hFFFF_FFFF;
        rpat[4] = 32'hFFFFFFFF; spat[4] = 32'h0000_0000;
        rpat[5] = 32'h7F80807F; spat[5] = 32'hDEAD_7F80;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // Reset-state inputs: aligned byte load of zero, no store (R10, R2).
        check("R10 idle enables", {28'h0, mem_be}, 32'h0);
        check("R2 idle load", load_result, 32'h0);
        check("R1 idle trap", {31'h0, align_trap}, 32'h0);

        for (int p = 0; p < 6; p++) begin
            for (int s = 0; s < 4; s++) begin
                for (int u = 0; u < 2; u++) begin
                    for (int o = 0; o < 4; o++) begin
                        for (int st = 0; st < 2; st++) begin
                            int nb;
                            bit exp_trap;
                            longint v;
                            longint mask;
                            logic [31:0] exp_ld;
                            logic [31:0] exp_wd;
                            logic [3:0]  exp_be;
                            string ld_req;

                            @(negedge clk);
                            req_size      = 2'(s);
                            load_unsigned = u[0];
                            addr_lo       = 2'(o);
                            store_req     = st[0];
                            mem_rdata     = rpat[p];
                            store_src     = spat[p];
                            // R11: sampled with no clock edge since the change
                            #2;

                            nb = (s == 0) ? 1 : (s == 1) ? 2 : (s == 2) ? 4 : 0;
                            exp_trap = (nb == 0) || ((o % nb) != 0);

                            exp_ld = 32'h0;
                            if (!exp_trap) begin
                                mask = (64'd1 << (8 * nb)) - 1;
                                v = (longint'(rpat[p]) >> (8 * (4 - o - nb))) & mask;
                                if (u == 0 && nb < 4 && ((v >> (8 * nb - 1)) & 1) == 1)
                                    v = v | (~mask & 64'hFFFF_FFFF);
                                exp_ld = 32'(v);
                            end

                            exp_be = 4'b0000;
                            if (st == 1 && !exp_trap) begin
                                if (nb == 1) exp_be = 4'(1 << (3 - o));
                                else if (nb == 2) exp_be = 4'(3 << (2 - o));
                                else exp_be = 4'hF;
                            end

                            if (nb == 1) exp_wd = {4{spat[p][7:0]}};
                            else if (nb == 2) exp_wd = {2{spat[p][15:0]}};
                            else exp_wd = spat[p];

                            check("R1 trap", {31'h0, align_trap}, {31'h0, exp_trap});

                            if (exp_trap) ld_req = "R9 load";
                            else if (nb == 4) ld_req = "R5 load";
                            else if (u == 1) ld_req = "R4 load";
                            else ld_req = "R3/R2 load";
                            check(ld_req, load_result, exp_ld);

                            if (exp_trap) check("R9 enables", {28'h0, mem_be}, {28'h0, exp_be});
                            else if (st == 0) check("R10 enables", {28'h0, mem_be}, {28'h0, exp_be});
                            else if (nb == 1) check("R6 enables", {28'h0, mem_be}, {28'h0, exp_be});
                            else if (nb == 2) check("R7 enables", {28'h0, mem_be}, {28'h0, exp_be});
                            else check("R8 enables", {28'h0, mem_be}, {28'h0, exp_be});

                            if (nb == 1) check("R6 wdata", mem_wdata, exp_wd);
                            else if (nb == 2) check("R7 wdata", mem_wdata, exp_wd);
                            else if (nb == 4) check("R8 wdata", mem_wdata, exp_wd);
                        end
                    end
                end
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule